// File: doc/BRIEF.md
# Frame Buffer Fetch Address Generator

This block walks through one displayed frame stored inside a wider virtual frame buffer and produces the memory read requests that fetch it. It is programmed with a start address in bytes, a byte skip that is added at the end of every visible line, the visible line length in 32-bit words, the frame size in words and a 5-bit sub-word pixel bit offset. It issues read bursts to a memory port that uses a request/grant handshake. It passes every returned word to a pixel FIFO, together with the bit offset at which the first pixel starts.

Software writes the start address, skip and bit offset and then pulses an update strobe. The new values are used from the next frame start pulse. Until that pulse the previous values stay active. The line length and frame size are taken at every frame start. A busy output tells software whether a fetch is still running, so it can wait for busy to drop before reprogramming. The enable input stops new bursts without cutting one short.

Top module: `fb_fetch_agen`

## Requirements
- R1: During reset and right after it, `mem_req`, `busy` and `fifo_wr` are low.
- R2: The first request of a frame carries the start address with bits [1:0] forced to zero. Every request address has bits [1:0] equal to zero.
- R3: Inside a line, the word addresses rise by 4 per word. After the last word of each line of `cfg_line_words` words, the skip in bytes is added to the running byte address before the next line begins. The request address is that running address with bits [1:0] cleared.
- R4: Each burst length is the smallest of `BURST` (default 8), the words left in the current line and the words left in the frame. The bursts of a frame add up to exactly `cfg_frame_words` words.
- R5: The start address, skip and bit offset change only at a frame start that follows a `cfg_update` pulse. A frame started with no update pending uses the previous values, even if the inputs have changed.
- R6: A frame start pulse reloads the address and the counters from the start of the frame. A pulse that arrives while a request waits for grant is held. The waiting request completes with its old address, and the next request fetches word 0 of the new frame.
- R7: A new burst is requested only when `fifo_space` is at least `BURST`.
- R8: Once `mem_req` is high, it stays high with `mem_addr` and `mem_len` unchanged until `mem_gnt` is sampled high.
- R9: Each word returned with `mem_rvalid` appears on `fifo_data` with `fifo_wr` high one cycle later. It comes with the active bit offset on `fifo_bit_off`.
- R10: `busy` is high from the frame start until the last word of the frame has been returned. When `en` goes low, no new burst is requested, but a burst already granted delivers all its words before `busy` drops.
- R11: A frame start with a zero frame size or a zero line length requests nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Fetch enable |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| cfg_update | input | 1 | Pulse that arms the new start address, skip and offset |
| cfg_base | input | ADDR_W | Frame start byte address |
| cfg_skip | input | SKIP_W | Bytes added after each visible line |
| cfg_bit_off | input | 5 | Sub-word bit offset of the first pixel |
| cfg_line_words | input | LINE_W | Visible line length in words |
| cfg_frame_words | input | FRAME_W | Frame size in words |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Word-aligned byte address of the burst |
| mem_len | output | LEN_W | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Returned read word valid |
| mem_rdata | input | DATA_W | Returned read word |
| fifo_space | input | SPACE_W | Free FIFO entries |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | FIFO write word |
| fifo_bit_off | output | 5 | Bit offset that goes with the pixel stream |
| busy | output | 1 | Fetch in progress |

## Verification
The bench targets line lengths that split bursts. If a design ignored the line end, a burst would run across the skip and fetch bytes from the hidden part of the virtual line. It also targets frame sizes that are not multiples of the line length; a wrong last-burst clip here would read past the frame. Two directed cases check the timing of the shadow registers. A frame started without an update must still use the old start address. A frame start raised while a request waits for grant must not change that request's address, which would break the handshake. The bench also drops the enable in the middle of a burst. A wrong design would either lower busy while data is still returning or keep requesting after the drop.

// File: rtl/fb_fetch_agen.sv
module fb_fetch_agen #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SKIP_W  = 16,
  parameter int LINE_W  = 12,
  parameter int FRAME_W = 20,
  parameter int BURST   = 8,
  parameter int SPACE_W = 8,
  localparam int LEN_W  = $clog2(BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               frame_start,
  input  logic               cfg_update,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SKIP_W-1:0]  cfg_skip,
  input  logic [4:0]         cfg_bit_off,
  input  logic [LINE_W-1:0]  cfg_line_words,
  input  logic [FRAME_W-1:0] cfg_frame_words,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LEN_W-1:0]   mem_len,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [SPACE_W-1:0] fifo_space,
  output logic               fifo_wr,
  output logic [DATA_W-1:0]  fifo_data,
  output logic [4:0]         fifo_bit_off,
  output logic               busy
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;
  st_t st;

  logic [ADDR_W-1:0]  act_base, cur_addr;
  logic [SKIP_W-1:0]  act_skip;
  logic [4:0]         act_off;
  logic [LINE_W-1:0]  act_line, line_left;
  logic [FRAME_W-1:0] frame_left, span_c;
  logic [LEN_W-1:0]   len_c, rem;
  logic               run, upd_pend, start_pend;
  logic               take_start, issue, line_end;

  assign take_start = (frame_start || start_pend) && (st != S_REQ);
  assign issue      = (st == S_IDLE) && run && en && !take_start &&
                      (fifo_space >= SPACE_W'(BURST));
  assign span_c     = (FRAME_W'(line_left) < frame_left) ? FRAME_W'(line_left) : frame_left;
  assign len_c      = (span_c < FRAME_W'(BURST)) ? span_c[LEN_W-1:0] : LEN_W'(BURST);
  assign line_end   = (line_left == LINE_W'(len_c));

  assign mem_req  = (st == S_REQ);
  assign mem_addr = cur_addr & ~ADDR_W'(3);
  assign mem_len  = len_c;
  assign busy     = run || (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      act_base     <= '0;
      act_skip     <= '0;
      act_off      <= '0;
      act_line     <= '0;
      cur_addr     <= '0;
      line_left    <= '0;
      frame_left   <= '0;
      rem          <= '0;
      run          <= 1'b0;
      upd_pend     <= 1'b0;
      start_pend   <= 1'b0;
      fifo_wr      <= 1'b0;
      fifo_data    <= '0;
      fifo_bit_off <= '0;
    end else begin
      fifo_wr      <= mem_rvalid;
      fifo_data    <= mem_rdata;
      fifo_bit_off <= act_off;

      case (st)
        S_IDLE: if (issue) st <= S_REQ;
        S_REQ: if (mem_gnt) begin
          cur_addr   <= cur_addr + ADDR_W'({len_c, 2'b00}) +
                        (line_end ? ADDR_W'(act_skip) : '0);
          line_left  <= line_end ? act_line : line_left - LINE_W'(len_c);
          frame_left <= frame_left - FRAME_W'(len_c);
          if (frame_left == FRAME_W'(len_c)) run <= 1'b0;
          rem        <= len_c;
          st         <= S_DATA;
        end
        S_DATA: if (mem_rvalid) begin
          rem <= rem - 1'b1;
          if (rem == LEN_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (frame_start && st == S_REQ) start_pend <= 1'b1;

      if (take_start) begin
        start_pend <= 1'b0;
        if (upd_pend) begin
          act_base <= cfg_base;
          act_skip <= cfg_skip;
          act_off  <= cfg_bit_off;
          cur_addr <= cfg_base & ~ADDR_W'(3);
          upd_pend <= 1'b0;
        end else begin
          cur_addr <= act_base & ~ADDR_W'(3);
        end
        act_line   <= cfg_line_words;
        line_left  <= cfg_line_words;
        frame_left <= cfg_frame_words;
        run        <= en && (cfg_frame_words != '0) && (cfg_line_words != '0);
      end

      if (cfg_update) upd_pend <= 1'b1;
      if (!en) run <= 1'b0;
    end
  end

endmodule

module fb_fetch_agen_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BURST   = 8,
  parameter int SPACE_W = 8,
  localparam int LEN_W  = $clog2(BURST + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [LEN_W-1:0]   mem_len,
  input logic               mem_gnt,
  input logic               mem_rvalid,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic [SPACE_W-1:0] fifo_space,
  input logic               fifo_wr,
  input logic [DATA_W-1:0]  fifo_data,
  input logic               busy
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!mem_req && !busy); // R1
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(BURST))); // R4

  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(fifo_space) >= SPACE_W'(BURST))); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len))); // R8

  AST_FIFO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> (fifo_wr && fifo_data == $past(mem_rdata))); // R9

  AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R10

endmodule

bind fb_fetch_agen fb_fetch_agen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST), .SPACE_W(SPACE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
  .mem_rdata(mem_rdata), .fifo_space(fifo_space), .fifo_wr(fifo_wr),
  .fifo_data(fifo_data), .busy(busy)
);

// File: tb/fb_fetch_agen_tb_top.sv
module fb_fetch_agen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, frame_start = 1'b0, cfg_update = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_skip = '0;
  logic [4:0]  cfg_bit_off = '0;
  logic [11:0] cfg_line_words = '0;
  logic [19:0] cfg_frame_words = '0;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [3:0]  mem_len;
  logic [7:0]  fifo_space = 8'd255;
  logic        fifo_wr, busy;
  logic [31:0] fifo_data;
  logic [4:0]  fifo_bit_off;

  always #2.5 clk = ~clk;

  fb_fetch_agen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
    .cfg_update(cfg_update), .cfg_base(cfg_base), .cfg_skip(cfg_skip),
    .cfg_bit_off(cfg_bit_off), .cfg_line_words(cfg_line_words),
    .cfg_frame_words(cfg_frame_words), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fifo_space(fifo_space), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_bit_off(fifo_bit_off), .busy(busy)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_base = '0;
  logic [15:0] m_skip = '0;
  logic [4:0]  m_off = '0;
  int m_line = 1, m_frame = 0;
  int req_w = 0, dat_w = 0;
  bit chk_data = 1'b1, hold_gnt = 1'b0, restart_after = 1'b0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(int w);
    logic [31:0] a;
    a = (m_base & ~32'd3) + 32'(w / m_line) * (32'(m_line) * 32'd4 + 32'(m_skip))
        + 32'(w % m_line) * 32'd4;
    return a & ~32'd3;
  endfunction

  function automatic int exp_len(int w);
    int l;
    l = 8;
    if (m_line - (w % m_line) < l) l = m_line - (w % m_line);
    if (m_frame - w < l) l = m_frame - w;
    return l;
  endfunction

  // memory responder: grants requests and returns words equal to their address
  initial begin
    logic [31:0] raddr;
    int pend;
    raddr = '0;
    pend = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend > 0 && ($urandom % 4) != 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = raddr;
        raddr += 32'd4;
        pend--;
      end
      mem_gnt = 1'b0;
      if (rst_n && mem_req && pend == 0 && !hold_gnt && ($urandom % 3) != 0) begin
        mem_gnt = 1'b1;
        check(mem_addr == exp_addr(req_w), "R3 request address", mem_addr, exp_addr(req_w));
        check(int'(mem_len) == exp_len(req_w), "R4 burst length", 32'(mem_len), 32'(exp_len(req_w)));
        raddr = mem_addr;
        pend = int'(mem_len);
        if (restart_after) begin
          req_w = 0;
          restart_after = 1'b0;
        end else begin
          req_w += int'(mem_len);
        end
      end
    end
  end

  // FIFO side monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fifo_wr && chk_data) begin
        check(fifo_data == exp_addr(dat_w), "R9 forwarded word", fifo_data, exp_addr(dat_w));
        check(fifo_bit_off == m_off, "R9 bit offset", 32'(fifo_bit_off), 32'(m_off));
        dat_w++;
      end
    end
  end

  task automatic start_frame(bit upd, logic [31:0] base, logic [15:0] skip,
                             logic [4:0] off, int line, int frame);
    @(negedge clk);
    cfg_base = base; cfg_skip = skip; cfg_bit_off = off;
    cfg_line_words = 12'(line); cfg_frame_words = 20'(frame);
    if (upd) begin
      cfg_update = 1'b1;
      m_base = base; m_skip = skip; m_off = off;
    end
    m_line = line; m_frame = frame; req_w = 0; dat_w = 0;
    @(negedge clk);
    cfg_update = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic run_full(bit upd, logic [31:0] base, logic [15:0] skip,
                          logic [4:0] off, int line, int frame, string tag);
    start_frame(upd, base, skip, off, line, frame);
    check(busy == 1'b1, {tag, " R10 busy after start"}, 32'(busy), 32'd1);
    wait_done();
    check(req_w == frame, {tag, " R4 words requested"}, 32'(req_w), 32'(frame));
    check(dat_w == frame, {tag, " R10 words delivered"}, 32'(dat_w), 32'(frame));
    check(busy == 1'b0, {tag, " R10 busy drops"}, 32'(busy), 32'd0);
  endtask

  initial begin
    int quiet;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!mem_req && !busy && !fifo_wr, "R1 reset outputs", {29'd0, mem_req, busy, fifo_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !busy && !fifo_wr, "R1 after reset", {29'd0, mem_req, busy, fifo_wr}, 32'd0);

    // R2: unaligned base, R3: line of 3 words with a skip
    run_full(1'b1, 32'h1000_0007, 16'd10, 5'd12, 3, 10, "directed");
    // R4: one-word lines and a frame shorter than a burst
    run_full(1'b1, 32'h0000_2000, 16'd4, 5'd1, 1, 5, "single-word lines");
    run_full(1'b1, 32'h0000_3000, 16'd0, 5'd0, 20, 6, "short frame");

    for (int i = 0; i < 8; i++)
      run_full(1'b1, $urandom, 16'($urandom % 64), 5'($urandom % 32),
               1 + int'($urandom % 20), 1 + int'($urandom % 90), "random");

    // R5: new inputs without update keep the old start address and skip
    run_full(1'b1, 32'h0000_4000, 16'd8, 5'd3, 5, 12, "R5 armed");
    run_full(1'b0, 32'h0000_9000, 16'd40, 5'd9, 5, 12, "R5 not armed");
    check(m_base == 32'h0000_4000, "R5 old base kept", m_base, 32'h0000_4000);

    // R7: no request while the FIFO lacks room for a burst
    fifo_space = 8'd7;
    start_frame(1'b1, 32'h0000_5000, 16'd0, 5'd0, 8, 16);
    quiet = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_req) quiet++;
    end
    check(quiet == 0, "R7 held off by FIFO space", 32'(quiet), 32'd0);
    fifo_space = 8'd8;
    wait_done();
    check(req_w == 16, "R7 resumes with room", 32'(req_w), 32'd16);
    fifo_space = 8'd255;

    // R10: dropping enable lets the granted burst finish
    start_frame(1'b1, 32'h0000_6000, 16'd0, 5'd2, 40, 160);
    while (req_w < 16) @(negedge clk);
    en = 1'b0;
    wait_done();
    check(req_w < 160, "R10 no new bursts after disable", 32'(req_w), 32'd160);
    check(dat_w == req_w, "R10 granted burst completes", 32'(dat_w), 32'(req_w));
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req || busy) quiet++;
    end
    check(quiet == 0, "R10 stays idle while disabled", 32'(quiet), 32'd0);
    en = 1'b1;

    // R6: frame start while a request waits for grant
    chk_data = 1'b0;
    hold_gnt = 1'b1;
    start_frame(1'b1, 32'h0000_7000, 16'd16, 5'd0, 6, 18);
    while (!mem_req) @(negedge clk);
    restart_after = 1'b1;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_req && mem_addr == 32'h0000_7000, "R6 waiting request unchanged", mem_addr, 32'h0000_7000);
    hold_gnt = 1'b0;
    wait_done();
    check(req_w == 18, "R6 restarted frame complete", 32'(req_w), 32'd18);
    chk_data = 1'b1;

    // R11: empty frame
    start_frame(1'b1, 32'h0000_8000, 16'd0, 5'd0, 4, 0);
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req || busy) quiet++;
    end
    check(quiet == 0, "R11 zero-size frame", 32'(quiet), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule